// File: doc/BRIEF.md
# Read-to-Write Bus Turnaround Sequencer

This block is the device-side timing sequencer for the data interface of a graphics DDR memory. Each clock it takes one decoded command (READ, WRITE or idle) together with a bank and column address. It then produces the control outputs that line up with the data bus. These are the read-data output enable, the read-strobe drive enable, the on-die termination enable for the data pins, a write-strobe gate, and the gated write-capture strobe. It also presents the bank, column and beat pair that the bus is carrying in each cycle.

Every burst moves four data beats, two per clock, so a burst occupies two clocks on the bus. A configuration input selects one of two latency pairs. A WRITE that comes too soon after a READ would collide with the returning read data. Such a WRITE is rejected, and a one-cycle error flag is raised. The latency select must be held steady while bursts are in flight.

Top module: `rtw_turnaround_seq`

## Requirements
- R1: While reset is asserted and immediately after it, rd_dq_oe, rd_dqs_oe, wr_dqs_gate, wr_capture and rtw_err are 0, dq_odt_en is 1, and beat_pair, beat_bank and beat_col are 0.
- R2: For a READ (cmd 2'b01) issued in cycle 0, rd_dq_oe is 1 in cycles RL and RL+1 only. In cycle RL, beat_pair is 0; in cycle RL+1, beat_pair is 1. In both cycles beat_bank and beat_col equal the READ's address.
- R3: dq_odt_en is 0 from cycle RL-1 through cycle RL+2 after a READ, and 1 otherwise.
- R4: rd_dqs_oe is 1 from cycle RL-1 (preamble) through cycle RL+1, and 0 otherwise.
- R5: For an accepted WRITE (cmd 2'b10) in cycle 0, the capture window covers cycles WL and WL+1. beat_pair is 0 and then 1 in those cycles, and beat_bank and beat_col carry the WRITE's address.
- R6: wr_dqs_gate is 1 from cycle WL-1 through WL+2. wr_capture equals wdqs_edge inside the capture window and is 0 outside it, whatever wdqs_edge does there.
- R7: lat_sel=0 selects RL=7, WL=3; lat_sel=1 selects RL=8, WL=4.
- R8: A WRITE issued k cycles after the last READ, with k below RTW_GAP (default 6), is dropped. It opens no gate and no capture window, and rtw_err is 1 for exactly the one following cycle. At k equal to RTW_GAP the WRITE is accepted and rtw_err stays 0.
- R9: The timing of a WRITE after a READ does not depend on whether the two commands use the same bank.
- R10: The read-data window and the write-capture window are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: 00 idle, 01 READ, 10 WRITE, 11 idle |
| cmd_bank | input | BANK_W | Bank address of the command |
| cmd_col | input | COL_W | Column address of the command |
| lat_sel | input | 1 | Latency pair select |
| wdqs_edge | input | 1 | Write strobe activity seen in this cycle |
| rd_dq_oe | output | 1 | Read data drive enable |
| rd_dqs_oe | output | 1 | Read strobe drive enable |
| dq_odt_en | output | 1 | Data pin termination enable |
| wr_dqs_gate | output | 1 | Write strobe receive gate, including preamble and postamble |
| wr_capture | output | 1 | Gated write-data capture strobe |
| beat_pair | output | 1 | Beat pair on the bus: 0 = beats 0/1, 1 = beats 2/3 |
| beat_bank | output | BANK_W | Bank of the burst on the bus |
| beat_col | output | COL_W | Column of the burst on the bus |
| rtw_err | output | 1 | One-cycle flag for a rejected early WRITE |

## Verification
With the WRITE placed exactly RTW_GAP cycles after the READ, several things happen in the same cycle. The last read-data clock, the read-strobe tail and the termination-off window all meet the opening of the write-strobe preamble gate. The directed scenario issues that exact spacing at both latency pairs. In every cycle it checks that the read enables and the write gate follow their own windows. It also checks that the read-data and capture windows never coincide. A second scenario issues the WRITE one cycle earlier and checks that only the error pulse appears.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;
endpackage

// File: rtl/burst_age_pipe.sv
// Tracks how many cycles ago each burst command was accepted.
// Entry i set means a command was taken i+1 cycles ago.
module burst_age_pipe #(
    parameter int DEPTH = 10,
    parameter int AW    = 13
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_addr,
    output logic [DEPTH-1:0]          age_vld,
    output logic [DEPTH-1:0][AW-1:0]  age_addr
);
    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][AW-1:0] addr;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d.vld[0]  = push;
        st_d.addr[0] = push ? push_addr : '0;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.vld[i]  = st_q.vld[i-1];
            st_d.addr[i] = st_q.addr[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign age_vld  = st_q.vld;
    assign age_addr = st_q.addr;
endmodule

// File: rtl/rtw_guard.sv
// Enforces the minimum READ-to-WRITE command spacing.
module rtw_guard #(
    parameter int GAP = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_rd,
    input  logic is_wr,
    output logic wr_ok,
    output logic err
);
    localparam int CW = $clog2(GAP + 1);

    typedef struct packed {
        logic [CW-1:0] since;
        logic          err;
    } guard_t;

    guard_t st_d, st_q;

    always_comb begin
        wr_ok = is_wr && (st_q.since >= CW'(GAP));
        st_d  = st_q;
        if (is_rd)                    st_d.since = CW'(1);
        else if (st_q.since < CW'(GAP)) st_d.since = st_q.since + CW'(1);
        st_d.err = is_wr && !wr_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.since <= CW'(GAP);
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err = st_q.err;
endmodule

// File: rtl/rtw_turnaround_seq.sv
module rtw_turnaround_seq
    import rtw_pkg::*;
#(
    parameter int BANK_W  = 3,
    parameter int COL_W   = 10,
    parameter int RL_LO   = 7,
    parameter int WL_LO   = 3,
    parameter int RL_HI   = 8,
    parameter int WL_HI   = 4,
    parameter int RTW_GAP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              lat_sel,
    input  logic              wdqs_edge,
    output logic              rd_dq_oe,
    output logic              rd_dqs_oe,
    output logic              dq_odt_en,
    output logic              wr_dqs_gate,
    output logic              wr_capture,
    output logic              beat_pair,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic              rtw_err
);
    localparam int AW       = BANK_W + COL_W;
    localparam int RL_MAX   = (RL_HI > RL_LO) ? RL_HI : RL_LO;
    localparam int WL_MAX   = (WL_HI > WL_LO) ? WL_HI : WL_LO;
    localparam int RD_DEPTH = RL_MAX + 2;
    localparam int WR_DEPTH = WL_MAX + 2;

    logic is_rd, is_wr, wr_ok;
    logic [RD_DEPTH-1:0]         rd_vld;
    logic [RD_DEPTH-1:0][AW-1:0] rd_addr;
    logic [WR_DEPTH-1:0]         wr_vld;
    logic [WR_DEPTH-1:0][AW-1:0] wr_addr;
    logic                        wr_cap_win;
    logic [AW-1:0]               beat_addr;

    assign is_rd = (cmd_e'(cmd) == CMD_READ);
    assign is_wr = (cmd_e'(cmd) == CMD_WRITE);

    rtw_guard #(.GAP(RTW_GAP)) guard_i (
        .clk   (clk),
        .rst_n (rst_n),
        .is_rd (is_rd),
        .is_wr (is_wr),
        .wr_ok (wr_ok),
        .err   (rtw_err)
    );

    burst_age_pipe #(.DEPTH(RD_DEPTH), .AW(AW)) rd_pipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (is_rd),
        .push_addr ({cmd_bank, cmd_col}),
        .age_vld   (rd_vld),
        .age_addr  (rd_addr)
    );

    burst_age_pipe #(.DEPTH(WR_DEPTH), .AW(AW)) wr_pipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_ok),
        .push_addr ({cmd_bank, cmd_col}),
        .age_vld   (wr_vld),
        .age_addr  (wr_addr)
    );

    // Cycle k after a command maps to age entry k-1.
    always_comb begin
        int rl, wl;
        logic odt_off;
        rl = lat_sel ? RL_HI : RL_LO;
        wl = lat_sel ? WL_HI : WL_LO;
        rd_dq_oe    = 1'b0;
        rd_dqs_oe   = 1'b0;
        odt_off     = 1'b0;
        wr_dqs_gate = 1'b0;
        wr_cap_win  = 1'b0;
        beat_pair   = 1'b0;
        beat_addr   = '0;
        for (int i = 0; i < RD_DEPTH; i++) begin
            if (rd_vld[i]) begin
                if (i >= rl - 1 && i <= rl)     rd_dq_oe  = 1'b1;
                if (i >= rl - 2 && i <= rl)     rd_dqs_oe = 1'b1;
                if (i >= rl - 2 && i <= rl + 1) odt_off   = 1'b1;
            end
        end
        for (int i = 0; i < WR_DEPTH; i++) begin
            if (wr_vld[i]) begin
                if (i >= wl - 1 && i <= wl)     wr_cap_win  = 1'b1;
                if (i >= wl - 2 && i <= wl + 1) wr_dqs_gate = 1'b1;
            end
        end
        // Address of the bus burst; the older burst wins any overlap.
        for (int i = WR_DEPTH - 1; i >= 0; i--) begin
            if (beat_addr == '0 && !beat_pair && wr_vld[i]) begin
                if (i == wl)          begin beat_pair = 1'b1; beat_addr = wr_addr[i]; end
                else if (i == wl - 1) begin beat_pair = 1'b0; beat_addr = wr_addr[i]; end
            end
        end
        for (int i = RD_DEPTH - 1; i >= 0; i--) begin
            if (rd_vld[i] && (i == rl || i == rl - 1) && !(rd_vld[rl] && i == rl - 1)) begin
                beat_pair = (i == rl);
                beat_addr = rd_addr[i];
            end
        end
        dq_odt_en  = !odt_off;
        wr_capture = wr_cap_win && wdqs_edge;
    end

    assign beat_bank = beat_addr[AW-1:COL_W];
    assign beat_col  = beat_addr[COL_W-1:0];
endmodule

// File: rtl/rtw_turnaround_chk.sv
module rtw_turnaround_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd,
    input logic       rd_dq_oe,
    input logic       rd_dqs_oe,
    input logic       dq_odt_en,
    input logic       wr_dqs_gate,
    input logic       wr_capture,
    input logic       rtw_err,
    input logic       wr_cap_win
);
    // R10
    no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_dq_oe && wr_cap_win));

    // R3
    odt_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_dq_oe) |-> !$past(dq_odt_en));

    // R3
    odt_off_during_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dq_oe |-> !dq_odt_en);

    // R4
    strobe_covers_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dq_oe |-> rd_dqs_oe);

    // R6
    capture_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_capture |-> wr_dqs_gate);

    // R8
    err_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtw_err |-> $past(cmd) == 2'b10);
endmodule

bind rtw_turnaround_seq rtw_turnaround_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .rd_dq_oe    (rd_dq_oe),
    .rd_dqs_oe   (rd_dqs_oe),
    .dq_odt_en   (dq_odt_en),
    .wr_dqs_gate (wr_dqs_gate),
    .wr_capture  (wr_capture),
    .rtw_err     (rtw_err),
    .wr_cap_win  (wr_cap_win)
);

// File: tb/rtw_turnaround_seq_tb.sv
module rtw_turnaround_seq_tb_top;
    localparam int K   = 18;
    localparam int GAP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [2:0] cmd_bank = '0;
    logic [9:0] cmd_col = '0;
    logic       lat_sel = 1'b0;
    logic       wdqs_edge = 1'b0;
    logic       rd_dq_oe, rd_dqs_oe, dq_odt_en, wr_dqs_gate, wr_capture;
    logic       beat_pair, rtw_err;
    logic [2:0] beat_bank;
    logic [9:0] beat_col;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic a_dq[0:K], a_dqs[0:K], a_odt[0:K], a_gate[0:K], a_cap[0:K], a_err[0:K], a_pair[0:K];
    logic [2:0] a_bank[0:K];
    logic [9:0] a_col[0:K];

    always #2.5 clk = ~clk;

    rtw_turnaround_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .lat_sel(lat_sel), .wdqs_edge(wdqs_edge), .rd_dq_oe(rd_dq_oe), .rd_dqs_oe(rd_dqs_oe),
        .dq_odt_en(dq_odt_en), .wr_dqs_gate(wr_dqs_gate), .wr_capture(wr_capture),
        .beat_pair(beat_pair), .beat_bank(beat_bank), .beat_col(beat_col), .rtw_err(rtw_err)
    );

    task automatic chk(input logic act, input logic exp, input string req, input int k);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", req, k, act, exp);
        end
    endtask

    task automatic chk_addr(input logic pr, input logic [2:0] b, input logic [9:0] c,
                            input logic epr, input logic [2:0] eb, input logic [9:0] ec,
                            input string req, input int k);
        checks++;
        if (pr !== epr || b !== eb || c !== ec) begin
            errors++;
            $display("FAIL %s cycle %0d: actual pair %0b bank %0d col %0d expected pair %0b bank %0d col %0d",
                     req, k, pr, b, c, epr, eb, ec);
        end
    endtask

    // READ in cycle 0 when do_rd; WRITE in cycle wr_at when wr_at >= 0.
    task automatic play(input bit do_rd, input int wr_at, input bit ls,
                        input logic [2:0] rb, input logic [9:0] rc,
                        input logic [2:0] wb, input logic [9:0] wc, input bit strobe);
        @(negedge clk);
        lat_sel   = ls;
        wdqs_edge = strobe;
        if (do_rd)           begin cmd = 2'b01; cmd_bank = rb; cmd_col = rc; end
        else if (wr_at == 0) begin cmd = 2'b10; cmd_bank = wb; cmd_col = wc; end
        for (int k = 1; k <= K; k++) begin
            @(negedge clk);
            a_dq[k] = rd_dq_oe;   a_dqs[k] = rd_dqs_oe; a_odt[k] = dq_odt_en;
            a_gate[k] = wr_dqs_gate; a_cap[k] = wr_capture; a_err[k] = rtw_err;
            a_pair[k] = beat_pair; a_bank[k] = beat_bank; a_col[k] = beat_col;
            if (k == wr_at) begin cmd = 2'b10; cmd_bank = wb; cmd_col = wc; end
            else            begin cmd = 2'b00; cmd_bank = '0; cmd_col = '0; end
        end
        wdqs_edge = 1'b0;
    endtask

    function automatic bit inw(input int k, input int lo, input int hi);
        return (k >= lo) && (k <= hi);
    endfunction

    task automatic check_read(input int rl, input logic [2:0] rb, input logic [9:0] rc, input string tag);
        for (int k = 1; k <= K; k++) begin
            chk(a_dq[k],  inw(k, rl, rl + 1),      {"R2 ", tag}, k);
            chk(a_odt[k], !inw(k, rl - 1, rl + 2), {"R3 ", tag}, k);
            chk(a_dqs[k], inw(k, rl - 1, rl + 1),  {"R4 ", tag}, k);
        end
        chk_addr(a_pair[rl], a_bank[rl], a_col[rl], 1'b0, rb, rc, {"R2 ", tag}, rl);
        chk_addr(a_pair[rl+1], a_bank[rl+1], a_col[rl+1], 1'b1, rb, rc, {"R2 ", tag}, rl + 1);
    endtask

    task automatic check_write(input int base, input int wl, input bit strobe,
                               input logic [2:0] wb, input logic [9:0] wc, input string tag);
        for (int k = 1; k <= K; k++) begin
            chk(a_gate[k], inw(k, base + wl - 1, base + wl + 2), {"R6 ", tag}, k);
            chk(a_cap[k],  strobe && inw(k, base + wl, base + wl + 1), {"R6 ", tag}, k);
        end
        chk_addr(a_pair[base+wl], a_bank[base+wl], a_col[base+wl], 1'b0, wb, wc, {"R5 ", tag}, base + wl);
        chk_addr(a_pair[base+wl+1], a_bank[base+wl+1], a_col[base+wl+1], 1'b1, wb, wc, {"R5 ", tag}, base + wl + 1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_dq_oe, 1'b0, "R1 in reset", 0);
        chk(dq_odt_en, 1'b1, "R1 in reset", 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(rd_dq_oe, 1'b0, "R1", 0);   chk(rd_dqs_oe, 1'b0, "R1", 0);
        chk(dq_odt_en, 1'b1, "R1", 0);  chk(wr_dqs_gate, 1'b0, "R1", 0);
        chk(wr_capture, 1'b0, "R1", 0); chk(rtw_err, 1'b0, "R1", 0);
        chk_addr(beat_pair, beat_bank, beat_col, 1'b0, 3'd0, 10'd0, "R1", 0);
    endtask

    task automatic t_read_lo;   // R2 R3 R4 R7 with lat_sel=0
        play(1, -1, 0, 3'd5, 10'h2A7, 3'd0, 10'd0, 0);
        check_read(7, 3'd5, 10'h2A7, "R7 lat0");
    endtask

    task automatic t_read_hi;   // R7 with lat_sel=1
        play(1, -1, 1, 3'd2, 10'h155, 3'd0, 10'd0, 0);
        check_read(8, 3'd2, 10'h155, "R7 lat1");
    endtask

    task automatic t_write_strobe;   // R5 R6: strobe active all the time
        play(0, 0, 0, 3'd0, 10'd0, 3'd6, 10'h0F3, 1);
        check_write(0, 3, 1, 3'd6, 10'h0F3, "wr lat0 strobe");
        for (int k = 1; k <= K; k++) chk(a_dq[k], 1'b0, "R5 no read", k);
    endtask

    task automatic t_write_quiet;   // R6: no strobe, gate still opens
        play(0, 0, 1, 3'd0, 10'd0, 3'd1, 10'h3FF, 0);
        check_write(0, 4, 0, 3'd1, 10'h3FF, "wr lat1 quiet");
    endtask

    task automatic t_turn(input bit ls, input logic [2:0] wb, input string tag);  // R8 R9 R10
        int rl, wl;
        rl = ls ? 8 : 7;
        wl = ls ? 4 : 3;
        play(1, GAP, ls, 3'd3, 10'h111, wb, 10'h222, 1);
        check_read(rl, 3'd3, 10'h111, tag);
        check_write(GAP, wl, 1, wb, 10'h222, {"R9 ", tag});
        for (int k = 1; k <= K; k++) begin
            chk(a_err[k], 1'b0, {"R8 ", tag}, k);
            chk(a_dq[k] && a_cap[k], 1'b0, {"R10 ", tag}, k);
        end
    endtask

    task automatic t_early_write;   // R8: write one cycle early is dropped
        play(1, GAP - 1, 0, 3'd4, 10'h0AA, 3'd4, 10'h0BB, 1);
        for (int k = 1; k <= K; k++) begin
            chk(a_err[k], (k == GAP), "R8 early", k);
            chk(a_gate[k], 1'b0, "R8 early gate", k);
            chk(a_cap[k], 1'b0, "R8 early cap", k);
        end
        check_read(7, 3'd4, 10'h0AA, "R8 early");
    endtask

    initial begin
        t_reset();
        t_read_lo();
        t_read_hi();
        t_write_strobe();
        t_write_quiet();
        t_turn(0, 3'd3, "same bank lat0");
        t_turn(1, 3'd0, "other bank lat1");
        t_turn(0, 3'd7, "other bank lat0");
        t_early_write();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule